// File: doc/BRIEF.md
# Channel Source Connection Sequencer

This block steers the source end of a point-to-point channel through its start-up and connection life cycle. A host drives a three-bit mode command: code 0 resets the sequencer, code 2 waits for the far end, and code 3 makes the channel operational. The far end reports its presence on an active-low interconnect line. The sequencer debounces that line over a fixed window of clock cycles and presents the result, inverted, as a destination-present status.

Once operational, a connect state machine drives the request, packet and burst lines of the channel from simple host commands. A connection is opened when the host asks for one and the far end accepts it. Packet and burst then follow the host's commands. If the far end disappears for a full filter window, every channel line drops at once and the machine latches into a failure state. From there it can only recover by a reset, then a wait, then an operational command. The interconnect line is debounced only after the sequencer has passed through the wait mode. A host that jumps straight from reset to operational sees the status stay low for good.

All control and status pins are plain levels, because no data stream passes through this block. The channel outputs are combinational in the connect state, the debounced status and the host's packet and burst commands.

Top module: `sc_source_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the clock edge after `mode_i` is 0, `src_link_o`, `dst_avail_o`, `request_o`, `packet_o` and `burst_o` are all low.
- R2: After the block has entered the wait state (the first edge with `mode_i` = 2 after a reset), `dst_avail_o` rises on the fourth consecutive edge at which `dst_link_n_i` is sampled low.
- R3: A change of `dst_link_n_i` that lasts fewer than four consecutive edges does not change `dst_avail_o` and does not disturb request, packet or burst.
- R4: If `mode_i` moves from 0 directly to 3, `dst_avail_o` and `request_o` stay low until the next `mode_i` = 0, even with `dst_link_n_i` held low.
- R5: With `dst_avail_o` high, `mode_i` = 3 moves the machine to idle. From idle, `conn_cmd_i` high with `mode_i` = 3 raises `request_o` on the next edge.
- R6: `packet_o` and `burst_o` stay low until `accept_i` has been seen high while `request_o` is high. After that, `packet_o` equals `pkt_cmd_i`, and `burst_o` is high only when `packet_o` and `burst_cmd_i` are both high.
- R7: When `dst_link_n_i` has been sampled high on four consecutive edges during operation, `dst_avail_o`, `request_o`, `packet_o` and `burst_o` all drop after the fourth edge, in the same cycle.
- R8: After such a loss, `dst_avail_o` stays low whatever `dst_link_n_i` does and through any mode 2 or 3 command. Only `mode_i` = 0, then 2, then 3 brings back `dst_avail_o` and the ability to raise `request_o`.
- R9: A mode code other than 0, 2 or 3 holds the current state and the filter, and starts no connection even with `conn_cmd_i` high.
- R10: `src_link_o` is high in every state except reset.
- R11: In a connection, dropping `conn_cmd_i` with `mode_i` = 3 returns the machine to idle, and `request_o` goes low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Mode command: 0 reset, 2 wait, 3 operational, other codes hold |
| dst_link_n_i | input | 1 | Active-low interconnect line from the destination |
| conn_cmd_i | input | 1 | Host asks for a connection to be opened or kept |
| accept_i | input | 1 | Destination has accepted the request |
| pkt_cmd_i | input | 1 | Host packet command |
| burst_cmd_i | input | 1 | Host burst command |
| src_link_o | output | 1 | Source-to-destination interconnect, high outside reset |
| dst_avail_o | output | 1 | Debounced, inverted destination-present status |
| request_o | output | 1 | Channel request line |
| packet_o | output | 1 | Channel packet line |
| burst_o | output | 1 | Channel burst line |

## Verification
The checker watches several properties on every cycle. The channel lines stay low whenever the status is low. Burst implies packet, and packet implies request. A rising status is always preceded by a full window of low samples. The failure state and the reset-to-operational blind state keep the status low. The quiet state after a mode-0 command and the hold under unused mode codes are also checked each cycle. Only the bench's scenarios can show the exact cycle at which the filter accepts a level, that short glitches pass unnoticed, the full reset-wait-operational recovery after a loss, and the packet and burst behaviour through a connection.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [2:0] MODE_RESET = 3'd0;
  localparam logic [2:0] MODE_WAIT  = 3'd2;
  localparam logic [2:0] MODE_OPER  = 3'd3;

  typedef enum logic [2:0] {
    CS_RST   = 3'd0,
    CS_WAIT  = 3'd1,
    CS_BLIND = 3'd2,
    CS_IDLE  = 3'd3,
    CS_REQ   = 3'd4,
    CS_CONN  = 3'd5,
    CS_LOST  = 3'd6
  } conn_state_e;
endpackage

// File: rtl/sc_link_filter.sv
module sc_link_filter #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic track_i,
  input  logic link_n_i,
  output logic present_o
);
  localparam int CNT_W = $clog2(WIN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             present_q;
  logic             sample;

  assign sample = ~link_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      present_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q     <= '0;
      present_q <= 1'b0;
    end else if (track_i) begin
      if (sample != present_q) begin
        if (cnt_q == LAST) begin
          present_q <= sample;
          cnt_q     <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign present_o = present_q;
endmodule

// File: rtl/sc_connect_fsm.sv
module sc_connect_fsm
  import sc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mode_i,
  input  logic        present_i,
  input  logic        conn_cmd_i,
  input  logic        accept_i,
  output conn_state_e state_o,
  output logic        track_o
);
  conn_state_e state_q, state_d;
  logic        oper, active_mode;

  assign oper        = (mode_i == MODE_OPER);
  assign active_mode = oper || (mode_i == MODE_WAIT);

  always_comb begin
    state_d = state_q;
    if (mode_i == MODE_RESET) begin
      state_d = CS_RST;
    end else begin
      unique case (state_q)
        CS_RST: begin
          if (mode_i == MODE_WAIT) state_d = CS_WAIT;
          else if (oper)           state_d = CS_BLIND;
        end
        CS_WAIT:  if (oper && present_i) state_d = CS_IDLE;
        CS_BLIND: state_d = CS_BLIND;
        CS_IDLE: begin
          if (!present_i)              state_d = CS_LOST;
          else if (oper && conn_cmd_i) state_d = CS_REQ;
        end
        CS_REQ: begin
          if (!present_i)                 state_d = CS_LOST;
          else if (oper && !conn_cmd_i)   state_d = CS_IDLE;
          else if (oper && accept_i)      state_d = CS_CONN;
        end
        CS_CONN: begin
          if (!present_i)               state_d = CS_LOST;
          else if (oper && !conn_cmd_i) state_d = CS_IDLE;
        end
        CS_LOST: state_d = CS_LOST;
        default: state_d = CS_RST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CS_RST;
    else        state_q <= state_d;
  end

  assign track_o = active_mode &&
                   (state_q == CS_WAIT || state_q == CS_IDLE ||
                    state_q == CS_REQ  || state_q == CS_CONN);
  assign state_o = state_q;
endmodule

// File: rtl/sc_source_ctrl.sv
module sc_source_ctrl
  import sc_pkg::*;
#(
  parameter int FILT_WIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       dst_link_n_i,
  input  logic       conn_cmd_i,
  input  logic       accept_i,
  input  logic       pkt_cmd_i,
  input  logic       burst_cmd_i,
  output logic       src_link_o,
  output logic       dst_avail_o,
  output logic       request_o,
  output logic       packet_o,
  output logic       burst_o
);
  conn_state_e conn_state;
  logic        present, track, linked, in_conn;

  sc_link_filter #(.WIN(FILT_WIN)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (mode_i == MODE_RESET),
    .track_i   (track),
    .link_n_i  (dst_link_n_i),
    .present_o (present)
  );

  sc_connect_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .present_i  (present),
    .conn_cmd_i (conn_cmd_i),
    .accept_i   (accept_i),
    .state_o    (conn_state),
    .track_o    (track)
  );

  assign linked  = (conn_state == CS_WAIT) || (conn_state == CS_IDLE) ||
                   (conn_state == CS_REQ)  || (conn_state == CS_CONN);
  assign in_conn = (conn_state == CS_CONN) && present;

  assign src_link_o  = (conn_state != CS_RST);
  assign dst_avail_o = present && linked;
  assign request_o   = present && ((conn_state == CS_REQ) || (conn_state == CS_CONN));
  assign packet_o    = in_conn && pkt_cmd_i;
  assign burst_o     = in_conn && pkt_cmd_i && burst_cmd_i;
endmodule

// File: rtl/sc_source_ctrl_chk.sv
module sc_source_ctrl_chk
  import sc_pkg::*;
#(
  parameter int WIN = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  mode_i,
  input logic        dst_link_n_i,
  input logic        conn_cmd_i,
  input logic        src_link_o,
  input logic        dst_avail_o,
  input logic        request_o,
  input logic        packet_o,
  input logic        burst_o,
  input conn_state_e state_i
);
  localparam int RUN_W = $clog2(WIN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(WIN);

  logic [RUN_W-1:0] low_run;
  logic             odd_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_run <= '0;
    else if (dst_link_n_i) low_run <= '0;
    else if (low_run != RUN_MAX) low_run <= low_run + 1'b1;
  end

  assign odd_mode = (mode_i != MODE_RESET) && (mode_i != MODE_WAIT) && (mode_i != MODE_OPER);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == MODE_RESET |=> !src_link_o && !dst_avail_o && !request_o && !packet_o);

  p_window_before_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dst_avail_o) |-> low_run >= RUN_MAX);

  p_blind_stays_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_i == CS_BLIND |-> !dst_avail_o && !request_o);

  p_burst_in_packet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_o |-> packet_o && request_o);

  p_packet_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    packet_o |-> request_o);

  p_lines_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_avail_o |-> !request_o && !packet_o && !burst_o);

  p_lost_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == CS_LOST && mode_i != MODE_RESET) |=> state_i == CS_LOST && !dst_avail_o);

  p_odd_mode_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == CS_IDLE && odd_mode && conn_cmd_i) |=> !request_o);

  p_link_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state_i != CS_RST |-> src_link_o);
endmodule

bind sc_source_ctrl sc_source_ctrl_chk #(.WIN(FILT_WIN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .dst_link_n_i (dst_link_n_i),
  .conn_cmd_i   (conn_cmd_i),
  .src_link_o   (src_link_o),
  .dst_avail_o  (dst_avail_o),
  .request_o    (request_o),
  .packet_o     (packet_o),
  .burst_o      (burst_o),
  .state_i      (conn_state)
);

// File: tb/sc_source_ctrl_bench.sv
module sc_source_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       link_n = 1'b1, conn = 1'b0, acc = 1'b0, pkt = 1'b0, bst = 1'b0;
  logic       src, av, rq, pk, bs;
  int         checks = 0;
  int         fails = 0;

  always #10 clk = ~clk;

  sc_source_ctrl u_sc_source_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .dst_link_n_i(link_n),
    .conn_cmd_i(conn), .accept_i(acc), .pkt_cmd_i(pkt), .burst_cmd_i(bst),
    .src_link_o(src), .dst_avail_o(av), .request_o(rq), .packet_o(pk), .burst_o(bs)
  );

  // Row: {mode, link_n conn accept pkt burst, expected src avail req pkt burst}
  localparam int NV = 49;
  localparam logic [12:0] VEC [NV] = '{
    {3'd0, 5'b00000, 5'b00000},  //  1 R1 reset quiet
    {3'd2, 5'b00000, 5'b10000},  //  2 R10 wait entered
    {3'd2, 5'b00000, 5'b10000},  //  3 R2
    {3'd2, 5'b00000, 5'b10000},  //  4 R2
    {3'd2, 5'b00000, 5'b10000},  //  5 R2
    {3'd2, 5'b00000, 5'b11000},  //  6 R2 fourth low sample
    {3'd3, 5'b00000, 5'b11000},  //  7 R5 idle
    {3'd3, 5'b01011, 5'b11100},  //  8 R6 request, no packet yet
    {3'd3, 5'b01010, 5'b11100},  //  9 R6
    {3'd3, 5'b01100, 5'b11100},  // 10 R6 accepted
    {3'd3, 5'b01010, 5'b11110},  // 11 R6 packet
    {3'd3, 5'b01011, 5'b11111},  // 12 R6 burst
    {3'd3, 5'b01001, 5'b11100},  // 13 R6 burst needs packet
    {3'd3, 5'b11011, 5'b11111},  // 14 R3 glitch
    {3'd3, 5'b11011, 5'b11111},  // 15 R3
    {3'd3, 5'b11011, 5'b11111},  // 16 R3
    {3'd3, 5'b01011, 5'b11111},  // 17 R3 glitch ends
    {3'd3, 5'b00000, 5'b11000},  // 18 R11 back to idle
    {3'd5, 5'b01000, 5'b11000},  // 19 R9 odd mode
    {3'd3, 5'b01000, 5'b11100},  // 20 R5
    {3'd3, 5'b01110, 5'b11110},  // 21 R6
    {3'd3, 5'b11010, 5'b11110},  // 22 R7
    {3'd3, 5'b11010, 5'b11110},  // 23 R7
    {3'd3, 5'b11010, 5'b11110},  // 24 R7
    {3'd3, 5'b11010, 5'b10000},  // 25 R7 loss accepted
    {3'd3, 5'b11010, 5'b10000},  // 26 R7
    {3'd3, 5'b01010, 5'b10000},  // 27 R8 far end back
    {3'd3, 5'b01010, 5'b10000},  // 28 R8
    {3'd3, 5'b01010, 5'b10000},  // 29 R8
    {3'd3, 5'b01010, 5'b10000},  // 30 R8
    {3'd3, 5'b01010, 5'b10000},  // 31 R8
    {3'd2, 5'b00000, 5'b10000},  // 32 R8 wait without reset
    {3'd2, 5'b00000, 5'b10000},  // 33 R8
    {3'd3, 5'b01000, 5'b10000},  // 34 R8
    {3'd0, 5'b00000, 5'b00000},  // 35 R1
    {3'd3, 5'b00000, 5'b10000},  // 36 R4 straight to operational
    {3'd3, 5'b01000, 5'b10000},  // 37 R4
    {3'd3, 5'b01000, 5'b10000},  // 38 R4
    {3'd3, 5'b01000, 5'b10000},  // 39 R4
    {3'd3, 5'b01000, 5'b10000},  // 40 R4
    {3'd3, 5'b01000, 5'b10000},  // 41 R4
    {3'd0, 5'b00000, 5'b00000},  // 42 R1
    {3'd2, 5'b00000, 5'b10000},  // 43 R8 recovery
    {3'd2, 5'b00000, 5'b10000},  // 44 R8
    {3'd2, 5'b00000, 5'b10000},  // 45 R8
    {3'd2, 5'b00000, 5'b10000},  // 46 R8
    {3'd2, 5'b00000, 5'b11000},  // 47 R8
    {3'd3, 5'b00000, 5'b11000},  // 48 R8
    {3'd3, 5'b01000, 5'b11100}   // 49 R8
  };
  localparam int ROW_REQ [NV] = '{1,10,2,2,2,2,5,6,6,6,6,6,6,3,3,3,3,11,9,5,6,
                                  7,7,7,7,7,8,8,8,8,8,8,8,8,1,4,4,4,4,4,4,1,
                                  8,8,8,8,8,8,8};

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b (src avail req pkt burst)", tag, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] m, input logic [4:0] ins);
    mode = m;
    {link_n, conn, acc, pkt, bst} = ins;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    check("R1 during reset", {src, av, rq, pk, bs}, 5'b00000);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][12:10], VEC[i][9:5]);
      check($sformatf("R%0d row %0d", ROW_REQ[i], i + 1), {src, av, rq, pk, bs}, VEC[i][4:0]);
    end

    // R1: asynchronous reset in the middle of a request
    rst_n = 1'b0;
    #1;
    check("R1 async reset", {src, av, rq, pk, bs}, 5'b00000);
    @(posedge clk);
    #2 rst_n = 1'b1;

    // R5: mode 3 given before the status is up, idle follows the rise
    step(3'd2, 5'b00000);
    step(3'd3, 5'b00000);
    step(3'd3, 5'b00000);
    step(3'd3, 5'b00000);
    step(3'd3, 5'b01000);
    check("R5 status up in wait, no request", {src, av, rq, pk, bs}, 5'b11000);
    step(3'd3, 5'b01000);
    check("R5 idle reached", {src, av, rq, pk, bs}, 5'b11000);
    step(3'd3, 5'b01000);
    check("R5 request raised", {src, av, rq, pk, bs}, 5'b11100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule